// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Serial Framer

This block is a full-duplex asynchronous serial transmitter and receiver for a single line pair. The frame shape is chosen at run time: five to eight data bits, one of five parity treatments, and a stop length of one, one and a half or two bit times. Bytes to send arrive through a valid/ready handshake. Each received frame comes out as a single-cycle pulse that carries the byte and three status flags: parity error, framing error and break.

Both directions share one oversampling tick. The tick is made by dividing the system clock by a run-time divisor, and one bit lasts sixteen ticks. With a 48 MHz system clock, divisors from 1 to 10000 give line rates from 3 Mbps down to 300 bps.

The block contains only the shift, sample and framing logic. The configuration inputs must not change while a frame is in progress in either direction.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset the transmit line is high, `tx_ready` is high and `rx_valid` is low. Whenever `tx_ready` is high, the transmit line is high.
- R2: `cfg_dlen` selects the data length: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits go least significant first. The transmitter ignores byte bits above the length, and the receiver returns them as zero.
- R3: `cfg_par` selects the parity: 0 is none, 1 is odd, 2 is even, 3 is mark (always 1) and 4 is space (always 0). Codes 5 to 7 act as none. The parity bit follows the last data bit, and with none there is no parity bit.
- R4: `cfg_stop` selects the stop length: 0 gives 16 ticks, 1 gives 24 ticks and 2 or 3 give 32 ticks. `tx_ready` returns high when the stop time ends.
- R5: One tick lasts `cfg_div` clock cycles and one bit lasts 16 ticks. A received frame is reported within one tick of the middle of its first stop bit.
- R6: A byte is taken on a rising edge where `tx_valid` and `tx_ready` are both high. After that edge, `tx_ready` stays low until the frame has been sent.
- R7: A falling edge on the receive line is accepted as a start bit only if the line is still low eight ticks later. A shorter low pulse produces no output.
- R8: Each received frame raises `rx_valid` for exactly one cycle, together with `rx_data` and the three flags.
- R9: `rx_perr` is set when the received parity bit differs from the bit the selected mode expects. It is never set when parity is none.
- R10: `rx_ferr` is set when the first stop bit is sampled low. The data byte is still delivered.
- R11: If every data bit, the parity bit (when present) and the stop bit are all low, the frame is reported with `rx_break` set, `rx_data` zero and the other flags clear. No further frame is reported until the line has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | DIV_W | Clock cycles per oversampling tick |
| cfg_dlen | input | 2 | Data length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| tx_line | output | 1 | Serial transmit line, high when idle |
| rx_line | input | 1 | Serial receive line, asynchronous |
| rx_data | output | 8 | Received byte, upper unused bits zero |
| rx_valid | output | 1 | One-cycle pulse per received frame |
| rx_perr | output | 1 | Parity mismatch in this frame |
| rx_ferr | output | 1 | First stop bit sampled low |
| rx_break | output | 1 | Frame was an all-low break |

## Verification
The phase of the free-running tick is unknown, so the transmitter's line falls one clock after acceptance and each bit is then checked at its middle: 8×`cfg_div` clocks after the observed fall, then every 16×`cfg_div` clocks. The whole frame, measured from the falling edge to the return of `tx_ready`, must fall within one tick of the length set by the data, parity and stop codes. On the receive side, `rx_valid` is due 8 + 16×(data + parity + 1) ticks after the start edge, plus three cycles for the synchronizer and the output register. The bench timestamps each pulse and accepts it only within one tick of that point. Glitch and break cases are judged by counting pulses over a window longer than any frame.

// File: rtl/ufe_pkg.sv
// Shared types and helper functions for the configurable serial framer.
// Assumes 16 oversampling ticks per bit; all helpers are pure combinational.
package ufe_pkg;

    localparam int BIT_TICKS  = 16;
    localparam int HALF_TICKS = BIT_TICKS / 2;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } fsm_e;

    // Data bit count for a length code (0..3 -> 5..8).
    function automatic logic [3:0] nbits_of(input logic [1:0] code);
        return {2'b00, code} + 4'd5;
    endfunction

    // Mask that keeps only the bits used by a length code.
    function automatic logic [7:0] mask_of(input logic [1:0] code);
        return 8'hFF >> (2'd3 - code);
    endfunction

    // Map reserved parity codes onto "none".
    function automatic par_mode_e norm_par(input logic [2:0] code);
        return (code > 3'd4) ? PAR_NONE : par_mode_e'(code);
    endfunction

    // Parity bit expected for masked data under a mode.
    function automatic logic par_of(input par_mode_e m, input logic [7:0] d);
        case (m)
            PAR_ODD:  return ~(^d);
            PAR_EVEN: return ^d;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    // Stop duration in ticks for a stop code.
    function automatic logic [5:0] stop_ticks(input logic [1:0] code);
        case (code)
            2'd0:    return 6'd16;
            2'd1:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/ufe_tick_gen.sv
// Oversampling tick generator: one-cycle tick every `div` clocks.
// Assumes div >= 1; the counter runs freely and is shared by both directions.
module ufe_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div - ONE);

    // Count clock cycles and wrap on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + ONE;
    end
endmodule

// File: rtl/ufe_tx.sv
// Frame serializer: start, 5-8 data bits LSB first, optional parity, stop.
// Assumes configuration is stable while a byte is accepted; it is latched then.
module ufe_tx
    import ufe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic [1:0] cfg_dlen,
    input  par_mode_e cfg_par,
    input  logic [1:0] cfg_stop,
    input  logic [7:0] data,
    input  logic      valid,
    output logic      ready,
    output logic      line
);
    fsm_e       st;
    logic [5:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic       pbit;
    logic [3:0] nbits_q;
    par_mode_e  par_q;
    logic [5:0] stop_lim_q;
    logic       line_next;
    logic [5:0] bit_lim;
    logic       bit_end;

    assign ready   = (st == ST_IDLE);
    assign bit_lim = (st == ST_STOP) ? stop_lim_q : 6'(BIT_TICKS);
    assign bit_end = tick && (tcnt == bit_lim - 6'd1);

    // Sequence the frame one bit time after another.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            sh         <= '0;
            pbit       <= 1'b0;
            nbits_q    <= 4'd5;
            par_q      <= PAR_NONE;
            stop_lim_q <= 6'd16;
        end else if (st == ST_IDLE) begin
            if (valid) begin
                sh         <= data & mask_of(cfg_dlen);
                pbit       <= par_of(cfg_par, data & mask_of(cfg_dlen));
                nbits_q    <= nbits_of(cfg_dlen);
                par_q      <= cfg_par;
                stop_lim_q <= stop_ticks(cfg_stop);
                tcnt       <= '0;
                bidx       <= '0;
                st         <= ST_START;
            end
        end else if (tick) begin
            if (bit_end) begin
                tcnt <= '0;
                case (st)
                    ST_START: st <= ST_DATA;
                    ST_DATA: begin
                        sh <= sh >> 1;
                        if ({1'b0, bidx} == nbits_q - 4'd1) begin
                            bidx <= '0;
                            st   <= (par_q == PAR_NONE) ? ST_STOP : ST_PAR;
                        end else begin
                            bidx <= bidx + 3'd1;
                        end
                    end
                    ST_PAR:  st <= ST_STOP;
                    default: st <= ST_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 6'd1;
            end
        end
    end

    // Select the line level for the current bit.
    always_comb begin
        case (st)
            ST_START: line_next = 1'b0;
            ST_DATA:  line_next = sh[0];
            ST_PAR:   line_next = pbit;
            default:  line_next = 1'b1;
        endcase
    end

    // Register the line so the pin never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) line <= 1'b1;
        else        line <= line_next;
    end
endmodule

// File: rtl/ufe_rx.sv
// Frame deserializer: synchronizes the line, revalidates the start bit at
// half a bit, samples mid-bit and flags parity, framing and break.
// Assumes configuration is stable from start edge to the stop sample.
module ufe_rx
    import ufe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_dlen,
    input  par_mode_e  cfg_par,
    input  logic       line,
    output logic [7:0] data,
    output logic       valid,
    output logic       perr,
    output logic       ferr,
    output logic       brk
);
    localparam logic [3:0] HALF_LAST = 4'(HALF_TICKS - 1);
    localparam logic [3:0] BIT_LAST  = 4'(BIT_TICKS - 1);

    logic       s1, s2;
    fsm_e       st;
    logic [3:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic [3:0] nbits_q;
    par_mode_e  par_q;
    logic       rpar;
    logic [7:0] aligned;
    logic       all_low;

    assign aligned = sh >> (4'd8 - nbits_q);
    assign all_low = (aligned == 8'h00) && ((par_q == PAR_NONE) || !rpar);

    // Two-flop synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= line;
            s2 <= s1;
        end
    end

    // Walk through the frame and report it at the first stop sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            nbits_q <= 4'd5;
            par_q   <= PAR_NONE;
            rpar    <= 1'b0;
            data    <= '0;
            valid   <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
            brk     <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                ST_IDLE: if (!s2) begin
                    st      <= ST_START;
                    tcnt    <= '0;
                    nbits_q <= nbits_of(cfg_dlen);
                    par_q   <= cfg_par;
                end
                ST_START: if (tick) begin
                    if (tcnt == HALF_LAST) begin
                        tcnt <= '0;
                        bidx <= '0;
                        sh   <= '0;
                        st   <= s2 ? ST_IDLE : ST_DATA;
                    end else tcnt <= tcnt + 4'd1;
                end
                ST_DATA: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (tcnt == BIT_LAST) begin
                        sh <= {s2, sh[7:1]};
                        if ({1'b0, bidx} == nbits_q - 4'd1)
                            st <= (par_q == PAR_NONE) ? ST_STOP : ST_PAR;
                        else
                            bidx <= bidx + 3'd1;
                    end
                end
                ST_PAR: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (tcnt == BIT_LAST) begin
                        rpar <= s2;
                        st   <= ST_STOP;
                    end
                end
                ST_STOP: if (tick) begin
                    tcnt <= tcnt + 4'd1;
                    if (tcnt == BIT_LAST) begin
                        valid <= 1'b1;
                        if (!s2 && all_low) begin
                            brk  <= 1'b1;
                            data <= '0;
                            perr <= 1'b0;
                            ferr <= 1'b0;
                        end else begin
                            brk  <= 1'b0;
                            data <= aligned;
                            ferr <= !s2;
                            perr <= (par_q != PAR_NONE) && (rpar != par_of(par_q, aligned));
                        end
                        st <= s2 ? ST_IDLE : ST_HOLD;
                    end
                end
                default: if (s2) st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_frame_engine.sv
// Top of the configurable serial framer: shared tick generator feeding an
// independent transmitter and receiver. Assumes the configuration inputs
// are held while either direction is busy.
module uart_frame_engine
    import ufe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_dlen,
    input  logic [2:0]       cfg_par,
    input  logic [1:0]       cfg_stop,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             tx_line,
    input  logic             rx_line,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_break
);
    logic      tick;
    par_mode_e par_mode;

    assign par_mode = norm_par(cfg_par);

    ufe_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
    );

    ufe_tx tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_dlen(cfg_dlen), .cfg_par(par_mode), .cfg_stop(cfg_stop),
        .data(tx_data), .valid(tx_valid), .ready(tx_ready), .line(tx_line)
    );

    ufe_rx rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_dlen(cfg_dlen), .cfg_par(par_mode), .line(rx_line),
        .data(rx_data), .valid(rx_valid), .perr(rx_perr),
        .ferr(rx_ferr), .brk(rx_break)
    );
endmodule

// File: rtl/ufe_checker.sv
// Port-level properties of the serial framer, bound to the top module.
module ufe_checker
    import ufe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_dlen,
    input logic [2:0] cfg_par,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_line,
    input logic [7:0] rx_data,
    input logic       rx_valid,
    input logic       rx_perr,
    input logic       rx_ferr,
    input logic       rx_break
);
    // R1: an idle transmitter holds the line high
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_line);

    // R6: an accepted byte makes the transmitter busy
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R8: the receive report is a single-cycle pulse
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2: unused upper bits of a received byte are zero
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data & ~mask_of(cfg_dlen)) == 8'h00));

    // R9: no parity error without a parity bit
    p_none_no_perr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && norm_par(cfg_par) == PAR_NONE) |-> !rx_perr);

    // R11: a break report carries no data and no other flag
    p_break_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_break) |-> (rx_data == 8'h00 && !rx_perr && !rx_ferr));
endmodule

bind uart_frame_engine ufe_checker chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_dlen(cfg_dlen), .cfg_par(cfg_par),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_break(rx_break)
);

// File: tb/uart_frame_engine_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random frames.
module uart_frame_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cfg_div;
    logic [1:0]  cfg_dlen;
    logic [2:0]  cfg_par;
    logic [1:0]  cfg_stop;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic        tx_line;
    logic        rx_line;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_perr;
    logic        rx_ferr;
    logic        rx_break;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rx_cnt = 0;
    int rx_cyc = 0;
    logic [7:0] got_d;
    logic got_p, got_f, got_b;
    bit done = 0;

    always #4 clk = ~clk;

    uart_frame_engine #(.DIV_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_dlen(cfg_dlen),
        .cfg_par(cfg_par), .cfg_stop(cfg_stop), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
        .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break)
    );

    always @(posedge clk) cyc++;

    // Record every receive report away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            rx_cyc = cyc;
            got_d  = rx_data;
            got_p  = rx_perr;
            got_f  = rx_ferr;
            got_b  = rx_break;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_par(input int pm, input logic [7:0] d);
        case (pm)
            1: return ~(^d);
            2: return ^d;
            3: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] mask_for(input int dl);
        return 8'hFF >> (3 - dl);
    endfunction

    function automatic int stop_len(input int sm);
        return (sm == 0) ? 16 : (sm == 1) ? 24 : 32;
    endfunction

    task automatic set_cfg(input int dl, input int pm, input int sm, input int dv);
        cfg_dlen = 2'(dl);
        cfg_par  = 3'(pm);
        cfg_stop = 2'(sm);
        cfg_div  = 16'(dv);
    endtask

    // Send one byte and decode the line mid-bit against the expected frame.
    task automatic tx_frame(input logic [7:0] d, input int dl, input int pm,
                            input int sm, input int dv);
        int nb = dl + 5;
        logic [7:0] md = d & mask_for(dl);
        int has_p = (pm >= 1 && pm <= 4) ? 1 : 0;
        int frame_t;
        int el = 0;
        @(negedge clk);
        set_cfg(dl, pm, sm, dv);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        check(tx_ready == 1'b0, "R6 busy after accept", int'(tx_ready), 0);
        while (tx_line) @(negedge clk);
        wait_clk(8 * dv); el += 8 * dv;
        check(tx_line == 1'b0, "R5 start bit mid-sample", int'(tx_line), 0);
        for (int i = 0; i < nb; i++) begin
            wait_clk(16 * dv); el += 16 * dv;
            check(tx_line == md[i], "R2 data bit LSB first", int'(tx_line), int'(md[i]));
        end
        if (has_p == 1) begin
            wait_clk(16 * dv); el += 16 * dv;
            check(tx_line == exp_par(pm, md), "R3 parity bit", int'(tx_line), int'(exp_par(pm, md)));
        end
        wait_clk(16 * dv); el += 16 * dv;
        check(tx_line == 1'b1, "R4 stop level", int'(tx_line), 1);
        while (!tx_ready) begin
            @(negedge clk);
            el++;
        end
        frame_t = (16 * (1 + nb + has_p) + stop_len(sm)) * dv;
        check(el >= frame_t - dv - 1 && el <= frame_t + 1, "R4 frame length", el, frame_t);
        check(tx_line == 1'b1, "R1 idle line after frame", int'(tx_line), 1);
    endtask

    // Drive one frame on the receive line and check the report.
    task automatic rx_frame(input logic [7:0] d, input int dl, input int pm,
                            input bit flip, input bit stopv, input int dv);
        int nb = dl + 5;
        logic [7:0] md = d & mask_for(dl);
        int has_p = (pm >= 1 && pm <= 4) ? 1 : 0;
        int c0, t0, k, lat;
        @(negedge clk);
        set_cfg(dl, pm, 0, dv);
        c0 = rx_cnt;
        rx_line = 1'b0;
        t0 = cyc;
        wait_clk(16 * dv);
        for (int i = 0; i < nb; i++) begin
            rx_line = md[i];
            wait_clk(16 * dv);
        end
        if (has_p == 1) begin
            rx_line = exp_par(pm, md) ^ flip;
            wait_clk(16 * dv);
        end
        rx_line = stopv;
        wait_clk(16 * dv);
        rx_line = 1'b1;
        wait_clk(32 * dv);
        check(rx_cnt == c0 + 1, "R8 one report per frame", rx_cnt - c0, 1);
        check(got_d == md, "R2 received byte", int'(got_d), int'(md));
        check(got_p == (flip && has_p == 1), "R9 parity flag", int'(got_p), int'(flip && has_p == 1));
        check(got_f == !stopv, "R10 framing flag", int'(got_f), int'(!stopv));
        check(got_b == 1'b0, "R11 no break on data frame", int'(got_b), 0);
        k = 8 + 16 * (nb + has_p + 1);
        lat = rx_cyc - t0;
        check(lat >= k * dv - dv && lat <= k * dv + 4, "R5 report timing", lat, k * dv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        tx_valid = 1'b0;
        tx_data = 8'h00;
        rx_line = 1'b1;
        set_cfg(3, 0, 0, 2);
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        check(tx_line == 1'b1, "R1 reset line high", int'(tx_line), 1);
        check(tx_ready == 1'b1, "R1 reset ready high", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R1 reset no report", int'(rx_valid), 0);

        // Directed transmit corners.
        tx_frame(8'hFF, 0, 1, 1, 2);   // 5 bits, odd, 1.5 stop, upper bits ignored
        tx_frame(8'hA5, 3, 3, 2, 3);   // mark parity, two stops
        tx_frame(8'h3C, 2, 4, 0, 2);   // space parity
        tx_frame(8'hC3, 1, 6, 0, 2);   // reserved parity code acts as none (R3)

        // Directed receive corners.
        rx_frame(8'hFF, 0, 2, 1'b1, 1'b1, 2);   // even parity flipped
        rx_frame(8'h81, 3, 3, 1'b0, 1'b1, 3);   // mark parity ok
        rx_frame(8'h5A, 3, 0, 1'b0, 1'b0, 2);   // R10 framing error, data kept

        // R7: short low pulse is not a start bit.
        @(negedge clk);
        set_cfg(3, 0, 0, 4);
        c0 = rx_cnt;
        rx_line = 1'b0;
        wait_clk(3 * 4);
        rx_line = 1'b1;
        wait_clk(40 * 4);
        check(rx_cnt == c0, "R7 glitch ignored", rx_cnt - c0, 0);
        rx_frame(8'h96, 3, 0, 1'b0, 1'b1, 4);

        // R11: line held low beyond a frame gives one break report.
        @(negedge clk);
        set_cfg(3, 2, 0, 2);
        c0 = rx_cnt;
        rx_line = 1'b0;
        wait_clk((16 * 11 + 48) * 2);
        check(rx_cnt == c0 + 1, "R11 single report while low", rx_cnt - c0, 1);
        rx_line = 1'b1;
        wait_clk(32 * 2);
        check(rx_cnt == c0 + 1, "R11 no extra report after release", rx_cnt - c0, 1);
        check(got_b == 1'b1, "R11 break flag", int'(got_b), 1);
        check(got_d == 8'h00, "R11 break data zero", int'(got_d), 0);
        check(!got_p && !got_f, "R11 break other flags clear", int'(got_p) + int'(got_f), 0);

        // Random transmit frames.
        for (int n = 0; n < 12; n++) begin
            tx_frame(8'($urandom), int'($urandom % 4), int'($urandom % 5),
                     int'($urandom % 3), 2 + int'($urandom % 3));
        end

        // Random receive frames with occasional parity corruption.
        for (int n = 0; n < 12; n++) begin
            int pm = int'($urandom % 5);
            rx_frame(8'($urandom), int'($urandom % 4), pm,
                     (pm != 0) && ($urandom % 4 == 0), 1'b1, 2 + int'($urandom % 3));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule